// File: doc/BRIEF.md
# Extended Register and Tag Allocator

This block is a physical register file in which every register carries a two-bit side store: a valid flag and a single data bit. The side store can hold a result of exactly 0 or 1 without touching the wide register. Tags handed to the rename stage are one bit wider than the register index. The extra top bit records whether the tag was given the side store together with its register (top bit 0) or the register alone (top bit 1). Because the tag already says where a 0 or 1 lands, a small result never forces a destination remap or a re-broadcast to dependent instructions.

Allocation pops an index from an ordinary free list and sets the top bit from the state of that index's side store. When a 0 or 1 result arrives under a top-bit-0 tag, the data bit is written and the wide register goes straight back to the free list. Another instruction can then take it as a top-bit-1 tag while the side store still serves the first one. Reads decode the tag and return either the side-store bit, zero-extended, or the register contents. Releases return whatever the tag still holds.

Top module: `ext_tag_regfile`

## Requirements
- R1: While reset is held, alloc_ack is 0 and rd_data reads 0. After reset the first NUM_REGS allocations hand out indices 0, 1, 2 and so on in ascending order, each with top bit 0. alloc_ack and alloc_tag appear in the cycle after alloc_req.
- R2: When the ascending supply is used up, returned indices are handed out in the order they were returned. A request with no free index gets alloc_ack 0.
- R3: An allocated tag has top bit 0 exactly when the index's side store is neither valid nor owned by a live tag, and the side store then becomes owned. Otherwise the tag has top bit 1.
- R4: A write of 0 or 1 (all bits above bit 0 clear) under a top-bit-0 tag sets the side store valid with that bit. It returns the index to the free list, so a later allocation hands that index out with top bit 1.
- R5: A write of any other value under a top-bit-0 tag goes to the register, leaves the side store invalid and keeps the index out of the free list.
- R6: A write under a top-bit-1 tag always goes to the register, including 0 and 1, and leaves the side store unchanged.
- R7: rd_data, one cycle after rd_tag is presented, is the zero-extended side-store bit when the tag has top bit 0 and the side store is valid. In every other case it is the register contents.
- R8: Releasing a top-bit-0 tag clears its side store's valid and owned flags. It returns the index to the free list only if the side store was not valid. Releasing a top-bit-1 tag returns the index and leaves the side store unchanged.
- R9: When wr_en is high and wr_tag equals rd_tag in the same cycle, the next rd_data is the value just written.
- R10: A side store is never valid unless it is owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one tag this cycle |
| alloc_ack | output | 1 | Registered: the previous request was granted |
| alloc_tag | output | TAG_W | Registered granted tag, top bit 0 = register plus side store |
| wr_en | input | 1 | Result write strobe |
| wr_tag | input | TAG_W | Tag of the result being written |
| wr_data | input | DATA_W | Result value |
| rd_tag | input | TAG_W | Tag to read |
| rd_data | output | DATA_W | Read value, one cycle after rd_tag |
| rel_en | input | 1 | Release strobe at commit or squash |
| rel_tag | input | TAG_W | Tag being released |

## Verification
The assertions watch the invariants that hold on every cycle. A side store is never valid without an owner, and a granted top-bit-0 tag always owns its side store. A small write under a top-bit-0 tag always fills the side store. Top-bit-1 writes and wide writes never fill it, a release clears it, and reads of a valid side store and bypassed reads return the right value. Some effects reach the ports only through a sequence of events: the FIFO order of returned indices, the exclusion of an index whose side store is still live, and the fact that releasing a side-store-only tag must not return the register twice. The bench scenarios are what show these, together with an exhaustive sweep of every data value through a register-only tag.

// File: rtl/etr_pkg.sv
package etr_pkg;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_REG,
    WR_EXT
  } wr_route_e;

  typedef enum logic [1:0] {
    REL_NONE,
    REL_REG,
    REL_EXT,
    REL_BOTH
  } rel_act_e;

  typedef enum logic [1:0] {
    SRC_RAM,
    SRC_EXT,
    SRC_BYP
  } rd_src_e;

endpackage

// File: rtl/etr_freelist.sv
module etr_freelist #(
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_req,
  output logic             pop_ok,
  output logic [IDX_W-1:0] pop_idx,
  input  logic             push_a_en,
  input  logic [IDX_W-1:0] push_a_idx,
  input  logic             push_b_en,
  input  logic [IDX_W-1:0] push_b_idx
);

  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] fresh_q;
  logic [CNT_W-1:0] fill_q;
  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] tail_q;
  logic [IDX_W-1:0] ring [NUM_REGS];

  logic             from_fresh;
  logic             deq;
  logic [IDX_W-1:0] slot_b;
  logic [IDX_W-1:0] tail_n;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    step = (p == IDX_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign from_fresh = (fresh_q < CNT_W'(NUM_REGS));
  assign pop_ok     = pop_req && (from_fresh || (fill_q != '0));
  assign pop_idx    = from_fresh ? fresh_q[IDX_W-1:0] : ring[head_q];
  assign deq        = pop_ok && !from_fresh;
  assign slot_b     = push_a_en ? step(tail_q) : tail_q;
  assign tail_n     = push_b_en ? step(slot_b) : slot_b;

  always_ff @(posedge clk) begin
    if (push_a_en) ring[tail_q] <= push_a_idx;
    if (push_b_en) ring[slot_b] <= push_b_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= '0;
      fill_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      if (pop_ok && from_fresh) fresh_q <= fresh_q + 1'b1;
      if (deq) head_q <= step(head_q);
      tail_q <= tail_n;
      fill_q <= fill_q + CNT_W'(push_a_en) + CNT_W'(push_b_en) - CNT_W'(deq);
    end
  end

endmodule

// File: rtl/etr_ext_bits.sv
module etr_ext_bits #(
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                claim_en,
  input  logic [IDX_W-1:0]    claim_idx,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                set_bit,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic [IDX_W-1:0]    q_idx,
  output logic                q_free,
  input  logic [IDX_W-1:0]    r_idx,
  output logic                r_valid,
  output logic                r_bit,
  input  logic [IDX_W-1:0]    k_idx,
  output logic                k_valid,
  output logic [NUM_REGS-1:0] valid_vec,
  output logic [NUM_REGS-1:0] owned_vec
);

  logic [NUM_REGS-1:0] valid_q;
  logic [NUM_REGS-1:0] owned_q;
  logic [NUM_REGS-1:0] bit_q;

  assign q_free    = !valid_q[q_idx] && !owned_q[q_idx];
  assign r_valid   = valid_q[r_idx];
  assign r_bit     = bit_q[r_idx];
  assign k_valid   = valid_q[k_idx];
  assign valid_vec = valid_q;
  assign owned_vec = owned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      owned_q <= '0;
    end else begin
      if (clr_en) begin
        valid_q[clr_idx] <= 1'b0;
        owned_q[clr_idx] <= 1'b0;
      end
      if (set_en) valid_q[set_idx] <= 1'b1;
      if (claim_en) owned_q[claim_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) bit_q[set_idx] <= set_bit;
  end

endmodule

// File: rtl/etr_data_ram.sv
module etr_data_ram #(
  parameter int DEPTH  = 128,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ext_tag_regfile.sv
module ext_tag_regfile #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TAG_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  output logic              alloc_ack,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rel_en,
  input  logic [TAG_W-1:0]  rel_tag
);

  import etr_pkg::*;

  localparam int XB = TAG_W - 1;

  // free list and allocation
  logic             fl_ok;
  logic [IDX_W-1:0] fl_idx;
  logic             ext_free;
  logic             ack_q;
  logic [TAG_W-1:0] tag_q;

  // write path
  logic [IDX_W-1:0] wr_idx;
  logic             wr_small;
  wr_route_e        route;

  // release path
  logic [IDX_W-1:0] rel_idx;
  logic             rel_live;
  rel_act_e         rel_act;

  // read path
  logic [IDX_W-1:0] rd_idx;
  logic             rx_valid;
  logic             rx_bit;
  logic             bypass;
  rd_src_e          src_q;
  logic             xbit_q;
  logic [DATA_W-1:0] byp_q;
  logic [DATA_W-1:0] ram_q;

  logic [NUM_REGS-1:0] ext_valid_vec;
  logic [NUM_REGS-1:0] ext_owned_vec;

  assign wr_idx   = wr_tag[IDX_W-1:0];
  assign wr_small = (wr_data[DATA_W-1:1] == '0);
  assign rel_idx  = rel_tag[IDX_W-1:0];
  assign rd_idx   = rd_tag[IDX_W-1:0];
  assign bypass   = wr_en && (wr_tag == rd_tag);

  always_comb begin
    route = WR_NONE;
    if (wr_en) route = (!wr_tag[XB] && wr_small) ? WR_EXT : WR_REG;
  end

  always_comb begin
    rel_act = REL_NONE;
    if (rel_en) begin
      if (rel_tag[XB])   rel_act = REL_REG;
      else if (rel_live) rel_act = REL_EXT;
      else               rel_act = REL_BOTH;
    end
  end

  etr_freelist #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_free (
    .clk        (clk),
    .rst        (rst),
    .pop_req    (alloc_req),
    .pop_ok     (fl_ok),
    .pop_idx    (fl_idx),
    .push_a_en  (route == WR_EXT),
    .push_a_idx (wr_idx),
    .push_b_en  ((rel_act == REL_REG) || (rel_act == REL_BOTH)),
    .push_b_idx (rel_idx)
  );

  etr_ext_bits #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_ext (
    .clk       (clk),
    .rst       (rst),
    .claim_en  (fl_ok && ext_free),
    .claim_idx (fl_idx),
    .set_en    (route == WR_EXT),
    .set_idx   (wr_idx),
    .set_bit   (wr_data[0]),
    .clr_en    ((rel_act == REL_EXT) || (rel_act == REL_BOTH)),
    .clr_idx   (rel_idx),
    .q_idx     (fl_idx),
    .q_free    (ext_free),
    .r_idx     (rd_idx),
    .r_valid   (rx_valid),
    .r_bit     (rx_bit),
    .k_idx     (rel_idx),
    .k_valid   (rel_live),
    .valid_vec (ext_valid_vec),
    .owned_vec (ext_owned_vec)
  );

  etr_data_ram #(
    .DEPTH  (NUM_REGS),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (route == WR_REG),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      tag_q <= '0;
    end else begin
      ack_q <= fl_ok;
      if (fl_ok) tag_q <= {!ext_free, fl_idx};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_EXT;
      xbit_q <= 1'b0;
    end else begin
      xbit_q <= rx_bit;
      if (bypass)                    src_q <= SRC_BYP;
      else if (!rd_tag[XB] && rx_valid) src_q <= SRC_EXT;
      else                           src_q <= SRC_RAM;
    end
  end

  always_ff @(posedge clk) begin
    if (bypass) byp_q <= wr_data;
  end

  always_comb begin
    case (src_q)
      SRC_EXT: rd_data = {{(DATA_W-1){1'b0}}, xbit_q};
      SRC_BYP: rd_data = byp_q;
      default: rd_data = ram_q;
    endcase
  end

  assign alloc_ack = ack_q;
  assign alloc_tag = tag_q;

endmodule

// File: rtl/etr_checker.sv
module etr_checker #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TAG_W   = IDX_W + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                alloc_ack,
  input logic [TAG_W-1:0]    alloc_tag,
  input logic                wr_en,
  input logic [TAG_W-1:0]    wr_tag,
  input logic [DATA_W-1:0]   wr_data,
  input logic [TAG_W-1:0]    rd_tag,
  input logic [DATA_W-1:0]   rd_data,
  input logic                rel_en,
  input logic [TAG_W-1:0]    rel_tag,
  input logic [NUM_REGS-1:0] ext_valid_vec,
  input logic [NUM_REGS-1:0] ext_owned_vec
);

  localparam int XB = TAG_W - 1;

  logic [IDX_W-1:0] w_idx;
  logic [IDX_W-1:0] r_idx;
  logic [IDX_W-1:0] k_idx;
  logic             w_small;

  assign w_idx   = wr_tag[IDX_W-1:0];
  assign r_idx   = rd_tag[IDX_W-1:0];
  assign k_idx   = rel_tag[IDX_W-1:0];
  assign w_small = (wr_data[DATA_W-1:1] == '0);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !alloc_ack);

  assert_grant_owns_ext_R3: assert property (@(posedge clk) disable iff (rst)
    alloc_ack && !alloc_tag[XB] |-> ext_owned_vec[alloc_tag[IDX_W-1:0]]);

  assert_small_fills_ext_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_tag[XB] && w_small |=> ext_valid_vec[$past(w_idx)]);

  assert_wide_keeps_ext_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_tag[XB] && !w_small && !ext_valid_vec[w_idx]
    |=> !ext_valid_vec[$past(w_idx)]);

  assert_regonly_write_ext_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_tag[XB] && !(rel_en && k_idx == w_idx)
    |=> ext_valid_vec[$past(w_idx)] == $past(ext_valid_vec[w_idx]));

  assert_ext_read_narrow_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_tag[XB] && ext_valid_vec[r_idx] && !(wr_en && wr_tag == rd_tag)
    |=> rd_data[DATA_W-1:1] == '0);

  assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
    rel_en && !rel_tag[XB]
    |=> !ext_valid_vec[$past(k_idx)] && !ext_owned_vec[$past(k_idx)]);

  assert_bypass_value_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_tag == rd_tag) |=> rd_data == $past(wr_data));

  assert_valid_needs_owner_R10: assert property (@(posedge clk) disable iff (rst)
    (ext_valid_vec & ~ext_owned_vec) == '0);

endmodule

bind ext_tag_regfile etr_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W)
) u_etr_checker (
  .clk           (clk),
  .rst           (rst),
  .alloc_ack     (alloc_ack),
  .alloc_tag     (alloc_tag),
  .wr_en         (wr_en),
  .wr_tag        (wr_tag),
  .wr_data       (wr_data),
  .rd_tag        (rd_tag),
  .rd_data       (rd_data),
  .rel_en        (rel_en),
  .rel_tag       (rel_tag),
  .ext_valid_vec (ext_valid_vec),
  .ext_owned_vec (ext_owned_vec)
);

// File: tb/ext_tag_regfile_bench.sv
module ext_tag_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 8;
  localparam int DW    = 8;
  localparam int TW    = 4;
  localparam int WATCH = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic          alloc_ack;
  logic [TW-1:0] alloc_tag;
  logic          wr_en = 1'b0;
  logic [TW-1:0] wr_tag = '0;
  logic [DW-1:0] wr_data = '0;
  logic [TW-1:0] rd_tag = '0;
  logic [DW-1:0] rd_data;
  logic          rel_en = 1'b0;
  logic [TW-1:0] rel_tag = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_tag_regfile #(.NUM_REGS(NREG), .DATA_W(DW)) u_ext_tag_regfile (
    .clk (clk), .rst (rst),
    .alloc_req (alloc_req), .alloc_ack (alloc_ack), .alloc_tag (alloc_tag),
    .wr_en (wr_en), .wr_tag (wr_tag), .wr_data (wr_data),
    .rd_tag (rd_tag), .rd_data (rd_data),
    .rel_en (rel_en), .rel_tag (rel_tag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(output logic ack, output logic [TW-1:0] tag);
    @(negedge clk) alloc_req = 1'b1;
    @(negedge clk) alloc_req = 1'b0;
    ack = alloc_ack;
    tag = alloc_tag;
  endtask

  task automatic do_write(input logic [TW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_tag = t; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [TW-1:0] t, output logic [DW-1:0] d);
    @(negedge clk) rd_tag = t;
    @(negedge clk) d = rd_data;
  endtask

  task automatic do_bypass(input logic [TW-1:0] t, input logic [DW-1:0] v,
                           output logic [DW-1:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_tag = t; wr_data = v; rd_tag = t; end
    @(negedge clk) wr_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_release(input logic [TW-1:0] t);
    @(negedge clk) begin rel_en = 1'b1; rel_tag = t; end
    @(negedge clk) rel_en = 1'b0;
  endtask

  // first-round result per index: indices 0,1,4,6 get a 0 or 1
  function automatic logic [DW-1:0] first_val(input int i);
    case (i)
      0: first_val = 8'h00;
      1: first_val = 8'h01;
      2: first_val = 8'h55;
      3: first_val = 8'h02;
      4: first_val = 8'h01;
      5: first_val = 8'hFF;
      6: first_val = 8'h00;
      default: first_val = 8'h80;
    endcase
  endfunction

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCH, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic          ack;
    logic [TW-1:0] tag;
    logic [DW-1:0] d;
    int            order [4];
    order[0] = 0; order[1] = 1; order[2] = 4; order[3] = 6;

    repeat (3) @(negedge clk);
    chk("R1 reset ack", {31'd0, alloc_ack}, 32'd0);
    chk("R1 reset rd_data", {24'd0, rd_data}, 32'd0);
    rst = 1'b0;

    // R1 R3: ascending indices with side store granted
    for (int i = 0; i < NREG; i++) begin
      do_alloc(ack, tag);
      chk("R1 first alloc ack", {31'd0, ack}, 32'd1);
      chk("R1 first alloc tag", {28'd0, tag}, i);
    end
    do_alloc(ack, tag);
    chk("R2 empty no ack", {31'd0, ack}, 32'd0);

    for (int i = 0; i < NREG; i++) do_write(TW'(i), first_val(i));
    // R5 R7 R4: wide values from register, small ones from side store
    for (int i = 0; i < NREG; i++) begin
      do_read(TW'(i), d);
      chk("R7 read top-bit-0", {24'd0, d}, {24'd0, first_val(i)});
    end

    // R2 R4 R3: freed indices in return order, now register-only
    for (int k = 0; k < 4; k++) begin
      do_alloc(ack, tag);
      chk("R4 regrant ack", {31'd0, ack}, 32'd1);
      chk("R4 regrant tag", {28'd0, tag}, 32'(8 + order[k]));
    end
    do_alloc(ack, tag);
    chk("R5 wide-held registers stay out", {31'd0, ack}, 32'd0);

    // R6: register-only tag stores 0/1 in the register
    do_write(4'h8, 8'h01);
    do_read(4'h8, d);
    chk("R6 reg-only write of 1", {24'd0, d}, 32'd1);
    do_read(4'h0, d);
    chk("R6 side store untouched", {24'd0, d}, 32'd0);
    do_write(4'h9, 8'h33);
    do_read(4'h9, d);
    chk("R6 reg-only wide", {24'd0, d}, 32'h33);
    do_read(4'h1, d);
    chk("R7 side store 1 kept", {24'd0, d}, 32'd1);

    // R9: bypass
    do_bypass(4'hC, 8'h77, d);
    chk("R9 bypass wide", {24'd0, d}, 32'h77);
    do_bypass(4'hE, 8'h00, d);
    chk("R9 bypass zero", {24'd0, d}, 32'd0);
    do_read(4'hC, d);
    chk("R9 stored after bypass", {24'd0, d}, 32'h77);

    // R8: releases
    do_release(4'h0);   // side store only, no return
    do_release(4'h2);   // register and side store
    do_release(4'h8);   // register only
    do_alloc(ack, tag);
    chk("R8 order first", {27'd0, ack, tag}, 32'h12);
    do_alloc(ack, tag);
    chk("R8 cleared side store regranted", {27'd0, ack, tag}, 32'h10);
    do_alloc(ack, tag);
    chk("R8 no double return", {31'd0, ack}, 32'd0);
    do_release(4'h9);
    do_alloc(ack, tag);
    chk("R3 live side store forces top bit 1", {27'd0, ack, tag}, 32'h19);

    // R5 then R4 on a fresh top-bit-0 tag
    do_write(4'h2, 8'h42);
    do_read(4'h2, d);
    chk("R5 wide under top-bit-0", {24'd0, d}, 32'h42);
    do_write(4'h2, 8'h01);
    do_read(4'h2, d);
    chk("R4 small switches to side store", {24'd0, d}, 32'd1);
    do_alloc(ack, tag);
    chk("R4 register returned", {27'd0, ack, tag}, 32'h1A);

    // R6 R9 R7: every value through a register-only tag
    for (int v = 0; v < 256; v++) begin
      do_bypass(4'h9, DW'(v), d);
      chk("R9 sweep bypass", {24'd0, d}, v);
      do_read(4'h9, d);
      chk("R6 sweep read", {24'd0, d}, v);
    end
    do_read(4'h1, d);
    chk("R6 side store after sweep", {24'd0, d}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule